// File: doc/BRIEF.md
# Per-Stream Time-Window Ingress Policer

The block classifies each received frame against a table of stream rules and decides whether it may enter the switch. A rule keys on the destination MAC address, either alone or together with the VLAN ID and priority code point of a tagged frame. When several rules match, the one with the lowest index is used. A frame that matches no rule passes unchanged and is marked as unmatched, so that normal forwarding handles it.

A matching rule can hold a cyclic reception window. The window is an open interval followed by a closed interval, and it repeats from a base time given in nanoseconds. Frames that arrive while the window is closed are dropped. Frames are also dropped when they are longer than the rule's length limit, when the rule carries an explicit drop action, or when the rule gives no destination. A frame that is not dropped leaves with the rule's egress port mask and its trap-to-CPU flag. A rule has a gate but neither ports nor trap is not valid, and it never matches.

Each rule has a frame-only drop counter that saturates. Software loads the rules with single field writes and reads the counters through a read that also clears them. Current time comes in on `now_i`. Between clocks it must advance by less than the shortest window period, and a rule's base time must not lie more than one period behind `now_i` when it is loaded.

Top module: `stream_gate_policer`

## Requirements
- R1: A rule matches a frame when the rule is enabled and the destination MAC is equal. A VLAN-aware rule also needs the frame to be tagged with equal VID and PCP. A VLAN-unaware rule ignores the tag, VID and PCP.
- R2: When more than one rule matches, the rule with the lowest index decides the result, and `res_rule_o` reports that index.
- R3: A frame with no matching rule gives pass=1, nomatch=1, drop=0, ports=0, trap=0 and rule=0.
- R4: The window of a gated rule is open when now >= base and (now - base) mod (open_len + close_len) < open_len. A matched frame that arrives while the window is closed is dropped. A rule without a gate is always open.
- R5: A gated rule with an empty port mask and trap clear never matches, and lower-priority rules are searched instead.
- R6: A matched frame that is not dropped leaves with the rule's port mask and trap flag. A rule with the drop action drops every frame it matches. A dropped frame leaves with ports=0 and trap=0.
- R7: A matched frame whose `frm_len_i` is greater than the rule's 11-bit length limit is dropped. A frame whose length equals the limit is not dropped for length.
- R8: A matched rule with an empty port mask and trap clear drops the frame.
- R9: Each frame dropped by a matched rule adds one to that rule's counter. The counter saturates at 2^CNT_W-1.
- R10: A read pulse on `cnt_rd_i` returns the addressed counter on `cnt_data_o`, with `cnt_valid_o` high, one cycle later, and clears the counter. A drop on the same rule in the same cycle leaves the counter at 1.
- R11: Every frame presented with `frm_valid_i` gives exactly one result with `res_valid_o` one cycle later, with exactly one of pass and drop set.
- R12: After reset every rule is disabled, every counter is zero and every result output is zero.
- R13: Config fields are selected by `cfg_fld_i` as follows: 0 = DMAC [47:0]; 1 = control; 2 = base time; 3 = open length [31:0]; 4 = close length [31:0]. The control word holds VID [11:0], PCP [14:12], VLAN-aware [15], enable [16], gated [17], trap [18], drop [19], length limit [30:20] and port mask [31+N_PORTS-1:31]. Writing the base, open or close field restarts the window at the base time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| now_i | input | TIME_W | Current time in ns |
| cfg_we_i | input | 1 | Config field write strobe |
| cfg_rule_i | input | IDX_W | Rule index for the write |
| cfg_fld_i | input | 3 | Field selector |
| cfg_wdata_i | input | 48 | Field data |
| cnt_rd_i | input | 1 | Counter read-and-clear pulse |
| cnt_rule_i | input | IDX_W | Counter index |
| cnt_data_o | output | CNT_W | Counter value read |
| cnt_valid_o | output | 1 | Counter value valid |
| frm_valid_i | input | 1 | Frame descriptor valid |
| frm_dmac_i | input | 48 | Destination MAC |
| frm_tagged_i | input | 1 | Frame has a VLAN tag |
| frm_vid_i | input | 12 | VLAN ID |
| frm_pcp_i | input | 3 | Priority code point |
| frm_len_i | input | LEN_W | Frame length in bytes |
| res_valid_o | output | 1 | Result valid |
| res_pass_o | output | 1 | Frame admitted |
| res_drop_o | output | 1 | Frame dropped |
| res_nomatch_o | output | 1 | No rule matched |
| res_ports_o | output | N_PORTS | Egress port mask |
| res_trap_o | output | 1 | Copy to CPU |
| res_rule_o | output | IDX_W | Rule that decided |

## Verification
A counter read-and-clear and a drop on the same rule can happen in the same cycle. The bench causes this on purpose: it sends a frame to the drop-action rule and reads that rule's counter in the same cycle. The read must return the count from before the drop, and a second read must return 1. Random frames also mix reads into traffic at random, and a bench model that applies the read before the increment checks every returned value.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
  localparam int CFG_W  = 48;
  localparam int SPAN_W = 32;
  localparam int VID_W  = 12;
  localparam int PCP_W  = 3;

  typedef enum logic [2:0] {
    FLD_DMAC  = 3'd0,
    FLD_CTRL  = 3'd1,
    FLD_BASE  = 3'd2,
    FLD_OPEN  = 3'd3,
    FLD_CLOSE = 3'd4
  } fld_e;

  localparam int C_PCP   = 12;
  localparam int C_AWARE = 15;
  localparam int C_EN    = 16;
  localparam int C_GATED = 17;
  localparam int C_TRAP  = 18;
  localparam int C_DROP  = 19;
  localparam int C_MTU   = 20;
  localparam int C_PORTS = 31;
endpackage

// File: rtl/sgp_rule.sv
module sgp_rule
  import sgp_pkg::*;
#(
  parameter int N_PORTS = 5,
  parameter int TIME_W  = 48,
  parameter int LEN_W   = 11
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  fld_e                 fld_i,
  input  logic [CFG_W-1:0]     wdata_i,
  input  logic [TIME_W-1:0]    now_i,
  input  logic [47:0]          dmac_i,
  input  logic                 tagged_i,
  input  logic [VID_W-1:0]     vid_i,
  input  logic [PCP_W-1:0]     pcp_i,
  input  logic [LEN_W-1:0]     len_i,
  output logic                 hit_o,
  output logic                 gate_ok_o,
  output logic                 mtu_bad_o,
  output logic                 no_dest_o,
  output logic                 drop_act_o,
  output logic [N_PORTS-1:0]   ports_o,
  output logic                 trap_o
);
  logic [47:0]        dmac_q;
  logic [VID_W-1:0]   vid_q;
  logic [PCP_W-1:0]   pcp_q;
  logic               aware_q, en_q, gated_q, trap_q, drop_q;
  logic [LEN_W-1:0]   mtu_q;
  logic [N_PORTS-1:0] ports_q;
  logic [TIME_W-1:0]  base_q, start_q;
  logic [SPAN_W-1:0]  open_q, close_q;

  logic [TIME_W-1:0]  period, next_start, eff_start, elapsed;
  logic               wrap;

  // tracker steps at most one period per clock; now_i must move slower than that
  always_comb begin
    period     = TIME_W'(open_q) + TIME_W'(close_q);
    next_start = start_q + period;
    wrap       = (period != '0) && (now_i >= next_start);
    eff_start  = wrap ? next_start : start_q;
    elapsed    = now_i - eff_start;
  end

  assign gate_ok_o  = !gated_q || ((now_i >= eff_start) && (elapsed < TIME_W'(open_q)));
  assign no_dest_o  = (ports_q == '0) && !trap_q;
  assign hit_o      = en_q && !(gated_q && no_dest_o) && (dmac_i == dmac_q) &&
                      (!aware_q || (tagged_i && (vid_i == vid_q) && (pcp_i == pcp_q)));
  assign mtu_bad_o  = len_i > mtu_q;
  assign drop_act_o = drop_q;
  assign ports_o    = ports_q;
  assign trap_o     = trap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dmac_q  <= '0; vid_q <= '0; pcp_q <= '0;
      aware_q <= 1'b0; en_q <= 1'b0; gated_q <= 1'b0; trap_q <= 1'b0; drop_q <= 1'b0;
      mtu_q   <= '0; ports_q <= '0;
      base_q  <= '0; start_q <= '0; open_q <= '0; close_q <= '0;
    end else if (wr_i) begin
      case (fld_i)
        FLD_DMAC: dmac_q <= wdata_i[47:0];
        FLD_CTRL: begin
          vid_q   <= wdata_i[VID_W-1:0];
          pcp_q   <= wdata_i[C_PCP +: PCP_W];
          aware_q <= wdata_i[C_AWARE];
          en_q    <= wdata_i[C_EN];
          gated_q <= wdata_i[C_GATED];
          trap_q  <= wdata_i[C_TRAP];
          drop_q  <= wdata_i[C_DROP];
          mtu_q   <= wdata_i[C_MTU +: LEN_W];
          ports_q <= wdata_i[C_PORTS +: N_PORTS];
        end
        FLD_BASE: begin
          base_q  <= wdata_i[TIME_W-1:0];
          start_q <= wdata_i[TIME_W-1:0];
        end
        FLD_OPEN: begin
          open_q  <= wdata_i[SPAN_W-1:0];
          start_q <= base_q;
        end
        FLD_CLOSE: begin
          close_q <= wdata_i[SPAN_W-1:0];
          start_q <= base_q;
        end
        default: ;
      endcase
    end else begin
      start_q <= eff_start;
    end
  end
endmodule

// File: rtl/sgp_pick.sv
module sgp_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     hit_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/sgp_drop_cnt.sv
module sgp_drop_cnt #(
  parameter int N     = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     inc_i,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_valid_o
);
  logic [CNT_W-1:0] cnt_q [N];

  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cnt_q[g] <= '0;
      else if (rd_i && (rd_idx_i == IDX_W'(g)))     cnt_q[g] <= inc_i[g] ? CNT_W'(1) : '0;
      else if (inc_i[g] && (cnt_q[g] != '1))        cnt_q[g] <= cnt_q[g] + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_i;
      rd_data_o  <= rd_i ? cnt_q[rd_idx_i] : '0;
    end
  end
endmodule

// File: rtl/stream_gate_policer.sv
module stream_gate_policer
  import sgp_pkg::*;
#(
  parameter int N_RULES = 8,
  parameter int N_PORTS = 5,
  parameter int TIME_W  = 48,
  parameter int LEN_W   = 11,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = $clog2(N_RULES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TIME_W-1:0]  now_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_rule_i,
  input  logic [2:0]         cfg_fld_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  input  logic               cnt_rd_i,
  input  logic [IDX_W-1:0]   cnt_rule_i,
  output logic [CNT_W-1:0]   cnt_data_o,
  output logic               cnt_valid_o,
  input  logic               frm_valid_i,
  input  logic [47:0]        frm_dmac_i,
  input  logic               frm_tagged_i,
  input  logic [VID_W-1:0]   frm_vid_i,
  input  logic [PCP_W-1:0]   frm_pcp_i,
  input  logic [LEN_W-1:0]   frm_len_i,
  output logic               res_valid_o,
  output logic               res_pass_o,
  output logic               res_drop_o,
  output logic               res_nomatch_o,
  output logic [N_PORTS-1:0] res_ports_o,
  output logic               res_trap_o,
  output logic [IDX_W-1:0]   res_rule_o
);
  logic [N_RULES-1:0] hit, gate_ok, mtu_bad, no_dest, drop_act, trap;
  logic [N_PORTS-1:0] ports [N_RULES];
  logic               found, drop_c;
  logic [IDX_W-1:0]   sel;
  logic [N_RULES-1:0] inc;

  for (genvar g = 0; g < N_RULES; g++) begin : g_rule
    sgp_rule #(.N_PORTS(N_PORTS), .TIME_W(TIME_W), .LEN_W(LEN_W)) i_rule (
      .clk_i, .rst_ni,
      .wr_i      (cfg_we_i && (cfg_rule_i == IDX_W'(g))),
      .fld_i     (fld_e'(cfg_fld_i)),
      .wdata_i   (cfg_wdata_i),
      .now_i,
      .dmac_i    (frm_dmac_i),
      .tagged_i  (frm_tagged_i),
      .vid_i     (frm_vid_i),
      .pcp_i     (frm_pcp_i),
      .len_i     (frm_len_i),
      .hit_o     (hit[g]),
      .gate_ok_o (gate_ok[g]),
      .mtu_bad_o (mtu_bad[g]),
      .no_dest_o (no_dest[g]),
      .drop_act_o(drop_act[g]),
      .ports_o   (ports[g]),
      .trap_o    (trap[g])
    );
  end

  sgp_pick #(.N(N_RULES), .IDX_W(IDX_W)) i_pick (
    .hit_i(hit), .found_o(found), .idx_o(sel)
  );

  assign drop_c = found && (!gate_ok[sel] || mtu_bad[sel] || no_dest[sel] || drop_act[sel]);
  assign inc    = (frm_valid_i && drop_c) ? (N_RULES'(1) << sel) : '0;

  sgp_drop_cnt #(.N(N_RULES), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni,
    .inc_i     (inc),
    .rd_i      (cnt_rd_i),
    .rd_idx_i  (cnt_rule_i),
    .rd_data_o (cnt_data_o),
    .rd_valid_o(cnt_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0; res_pass_o <= 1'b0; res_drop_o <= 1'b0;
      res_nomatch_o <= 1'b0; res_ports_o <= '0; res_trap_o <= 1'b0; res_rule_o <= '0;
    end else begin
      res_valid_o   <= frm_valid_i;
      res_pass_o    <= frm_valid_i && !drop_c;
      res_drop_o    <= frm_valid_i && drop_c;
      res_nomatch_o <= frm_valid_i && !found;
      res_ports_o   <= (frm_valid_i && found && !drop_c) ? ports[sel] : '0;
      res_trap_o    <= frm_valid_i && found && !drop_c && trap[sel];
      res_rule_o    <= (frm_valid_i && found) ? sel : '0;
    end
  end
endmodule

// File: rtl/sgp_chk.sv
module sgp_chk #(
  parameter int N_PORTS = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frm_valid_i,
  input logic               cnt_rd_i,
  input logic               cnt_valid_o,
  input logic               res_valid_o,
  input logic               res_pass_o,
  input logic               res_drop_o,
  input logic               res_nomatch_o,
  input logic               res_trap_o,
  input logic [N_PORTS-1:0] res_ports_o
);
  // R11
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i |=> (res_valid_o && $countones({res_pass_o, res_drop_o}) == 1));
  // R3
  nomatch_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_nomatch_o) |-> (res_pass_o && !res_trap_o && res_ports_o == '0));
  // R6
  drop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_drop_o |-> (res_ports_o == '0 && !res_trap_o));
  // R10
  rd_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rd_i |=> cnt_valid_o);
  // R12
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (!res_pass_o && !res_drop_o && !res_nomatch_o));
endmodule

bind stream_gate_policer sgp_chk #(.N_PORTS(N_PORTS)) i_sgp_chk (
  .clk_i, .rst_ni, .frm_valid_i, .cnt_rd_i, .cnt_valid_o, .res_valid_o,
  .res_pass_o, .res_drop_o, .res_nomatch_o, .res_trap_o, .res_ports_o
);

// File: tb/test_stream_gate_policer.sv
`timescale 1ns/1ps
module test_stream_gate_policer;
  localparam int NR = 8, NP = 5, TW = 48, LW = 11, CW = 4, IW = 3;

  logic clk = 0, rst_n = 0;
  logic [TW-1:0] now = '0;
  logic cfg_we = 0; logic [IW-1:0] cfg_rule = 0; logic [2:0] cfg_fld = 0; logic [47:0] cfg_wdata = 0;
  logic cnt_rd = 0; logic [IW-1:0] cnt_rule = 0; logic [CW-1:0] cnt_data; logic cnt_valid;
  logic fv = 0; logic [47:0] fdmac = 0; logic ftag = 0; logic [11:0] fvid = 0; logic [2:0] fpcp = 0;
  logic [LW-1:0] flen = 0;
  logic rv, rpass, rdrop, rnm, rtrap; logic [NP-1:0] rports; logic [IW-1:0] rrule;

  int checks = 0, errors = 0;

  stream_gate_policer #(.N_RULES(NR), .N_PORTS(NP), .TIME_W(TW), .LEN_W(LW), .CNT_W(CW))
  i_stream_gate_policer (
    .clk_i(clk), .rst_ni(rst_n), .now_i(now),
    .cfg_we_i(cfg_we), .cfg_rule_i(cfg_rule), .cfg_fld_i(cfg_fld), .cfg_wdata_i(cfg_wdata),
    .cnt_rd_i(cnt_rd), .cnt_rule_i(cnt_rule), .cnt_data_o(cnt_data), .cnt_valid_o(cnt_valid),
    .frm_valid_i(fv), .frm_dmac_i(fdmac), .frm_tagged_i(ftag), .frm_vid_i(fvid),
    .frm_pcp_i(fpcp), .frm_len_i(flen),
    .res_valid_o(rv), .res_pass_o(rpass), .res_drop_o(rdrop), .res_nomatch_o(rnm),
    .res_ports_o(rports), .res_trap_o(rtrap), .res_rule_o(rrule)
  );

  always #5 clk = ~clk;
  always @(negedge clk) now <= now + 10;

  // bench model
  logic [47:0] m_dmac [NR];
  logic [11:0] m_vid [NR]; logic [2:0] m_pcp [NR];
  bit m_aw [NR], m_en [NR], m_gt [NR], m_tr [NR], m_dr [NR];
  logic [LW-1:0] m_mtu [NR]; logic [NP-1:0] m_pt [NR];
  longint m_base [NR], m_open [NR], m_close [NR];
  int m_cnt [NR];

  localparam logic [47:0] MA = 48'h42be249b7620, MB = 48'h0a0000000002, MC = 48'h0a0000000003,
                          MD = 48'h0a0000000004, ME = 48'h0a0000000005, MF = 48'h0a0000000006;

  task automatic chk(string tag, bit ok, string act, string exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual %s expected %s", tag, act, exp); end
  endtask

  task automatic wr(int r, int f, logic [47:0] d);
    @(negedge clk); cfg_we = 1; cfg_rule = IW'(r); cfg_fld = 3'(f); cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  // R13 control word encoding
  task automatic load(int r, logic [47:0] mac, bit aw, logic [11:0] vid, logic [2:0] pcp, bit en,
                      bit gt, bit tr, bit dr, int mtu, logic [NP-1:0] pt, longint b, longint o, longint c);
    logic [47:0] w;
    w = '0; w[11:0] = vid; w[14:12] = pcp; w[15] = aw; w[16] = en; w[17] = gt; w[18] = tr;
    w[19] = dr; w[30:20] = 11'(mtu); w[31 +: NP] = pt;
    m_dmac[r] = mac; m_aw[r] = aw; m_vid[r] = vid; m_pcp[r] = pcp; m_en[r] = en; m_gt[r] = gt;
    m_tr[r] = tr; m_dr[r] = dr; m_mtu[r] = 11'(mtu); m_pt[r] = pt;
    m_base[r] = b; m_open[r] = o; m_close[r] = c;
    wr(r, 0, mac); wr(r, 2, 48'(b)); wr(r, 3, 48'(o)); wr(r, 4, 48'(c)); wr(r, 1, w);
  endtask

  function automatic bit gate_open(int r, longint t);
    if (!m_gt[r]) return 1;
    if (t < m_base[r]) return 0;
    return ((t - m_base[r]) % (m_open[r] + m_close[r])) < m_open[r];
  endfunction

  // one cycle: frame (optional) plus counter read (optional), all results checked
  task automatic step(string tag, bit v, logic [47:0] mac, bit tg, logic [11:0] vid,
                      logic [2:0] pcp, int len, bit rd, int ridx);
    int sel; bit found, drop, inc; longint t; int exp_cnt;
    bit e_pass, e_drop, e_nm, e_tr; logic [NP-1:0] e_pt; int e_rule;
    fv = v; fdmac = mac; ftag = tg; fvid = vid; fpcp = pcp; flen = LW'(len);
    cnt_rd = rd; cnt_rule = IW'(ridx);
    @(posedge clk); t = longint'(now);
    found = 0; sel = 0;
    for (int i = NR - 1; i >= 0; i--)
      if (m_en[i] && !(m_gt[i] && m_pt[i] == 0 && !m_tr[i]) && m_dmac[i] == mac &&
          (!m_aw[i] || (tg && m_vid[i] == vid && m_pcp[i] == pcp))) begin found = 1; sel = i; end
    drop = found && (!gate_open(sel, t) || len > int'(m_mtu[sel]) || m_dr[sel] ||
                     (m_pt[sel] == 0 && !m_tr[sel]));
    e_pass = v && !drop; e_drop = v && drop; e_nm = v && !found;
    e_pt = (v && found && !drop) ? m_pt[sel] : '0; e_tr = v && found && !drop && m_tr[sel];
    e_rule = (v && found) ? sel : 0;
    inc = v && drop;
    exp_cnt = rd ? m_cnt[ridx] : 0;
    if (rd) m_cnt[ridx] = (inc && ridx == sel) ? 1 : 0;
    if (inc && !(rd && ridx == sel) && m_cnt[sel] < (1 << CW) - 1) m_cnt[sel]++;
    #1;
    chk(tag, rv == v && rpass == e_pass && rdrop == e_drop && rnm == e_nm && rports == e_pt &&
             rtrap == e_tr && int'(rrule) == e_rule,
        $sformatf("v%0d p%0d d%0d n%0d pt%b tr%0d r%0d", rv, rpass, rdrop, rnm, rports, rtrap, rrule),
        $sformatf("v%0d p%0d d%0d n%0d pt%b tr%0d r%0d", v, e_pass, e_drop, e_nm, e_pt, e_tr, e_rule));
    if (rd) chk({tag, "/R10 cnt"}, cnt_valid && int'(cnt_data) == exp_cnt,
                $sformatf("%0d", cnt_data), $sformatf("%0d", exp_cnt));
    @(negedge clk); fv = 0; cnt_rd = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    for (int i = 0; i < NR; i++) begin
      m_dmac[i] = 0; m_vid[i] = 0; m_pcp[i] = 0; m_aw[i] = 0; m_en[i] = 0; m_gt[i] = 0;
      m_tr[i] = 0; m_dr[i] = 0; m_mtu[i] = 0; m_pt[i] = 0; m_base[i] = 0; m_open[i] = 0;
      m_close[i] = 0; m_cnt[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 res", !rv && !rpass && !rdrop && !rnm && rports == 0 && !rtrap,
        $sformatf("%0d%0d%0d", rv, rpass, rdrop), "000");
    step("R12 cnt", 1'b1, MA, 1'b0, 12'd0, 3'd0, 100, 1'b1, 0);

    load(0, MA, 1, 12'd100, 3'd3, 1, 0, 0, 0, 1500, 5'b00110, 0, 0, 0);
    load(1, MA, 0, 12'd0, 3'd0, 1, 1, 1, 0, 2047, 5'b00001, 2000, 300, 200);
    load(2, MB, 0, 12'd0, 3'd0, 1, 0, 1, 1, 2047, 5'b00011, 0, 0, 0);
    load(3, MC, 0, 12'd0, 3'd0, 1, 1, 0, 0, 2047, 5'b00000, 1000, 100, 100);
    load(4, MC, 0, 12'd0, 3'd0, 1, 0, 0, 0, 2047, 5'b00000, 0, 0, 0);
    load(5, MD, 0, 12'd0, 3'd0, 1, 0, 0, 0, 64, 5'b10000, 0, 0, 0);
    load(6, ME, 0, 12'd0, 3'd0, 1, 1, 1, 0, 2047, 5'b00000, 2500, 100, 400);
    load(7, MF, 0, 12'd0, 3'd0, 0, 0, 1, 0, 2047, 5'b11111, 0, 0, 0);

    step("R2 aware wins", 1, MA, 1, 12'd100, 3'd3, 200, 0, 0);
    step("R1 vid mismatch", 1, MA, 1, 12'd101, 3'd3, 200, 0, 0);
    step("R1 untagged", 1, MA, 0, 12'd100, 3'd3, 200, 0, 0);
    step("R3 unknown", 1, 48'h123456789abc, 0, 12'd0, 3'd0, 200, 0, 0);
    step("R1 disabled", 1, MF, 0, 12'd0, 3'd0, 200, 0, 0);
    step("R5 invalid gate", 1, MC, 0, 12'd0, 3'd0, 200, 0, 0);
    step("R8 empty dest", 1, MC, 1, 12'd5, 3'd1, 200, 0, 4);
    step("R6 drop act", 1, MB, 0, 12'd0, 3'd0, 200, 0, 0);
    step("R7 at limit", 1, MD, 0, 12'd0, 3'd0, 64, 0, 0);
    step("R7 over limit", 1, MD, 0, 12'd0, 3'd0, 65, 0, 0);
    step("R4 before base", 1, ME, 0, 12'd0, 3'd0, 100, 0, 0);
    step("R11 idle", 0, MA, 0, 12'd0, 3'd0, 100, 0, 0);

    // R4 sweep through several windows of rules 1 and 6
    while (now < 48'd4200) begin
      step("R4 win1", 1, MA, 0, 12'd0, 3'd0, 300, 0, 0);
      step("R4 win6", 1, ME, 0, 12'd0, 3'd0, 300, 0, 0);
    end

    // R9 saturation on rule 2
    for (int i = 0; i < 20; i++) step("R9 fill", 1, MB, 0, 12'd0, 3'd0, 80, 0, 0);
    step("R9 sat read", 0, MB, 0, 12'd0, 3'd0, 80, 1, 2);
    // R10 read and drop in the same cycle
    for (int i = 0; i < 3; i++) step("R9 inc", 1, MB, 0, 12'd0, 3'd0, 80, 0, 0);
    step("R10 read+drop", 1, MB, 0, 12'd0, 3'd0, 80, 1, 2);
    step("R10 after", 0, MB, 0, 12'd0, 3'd0, 80, 1, 2);
    step("R10 cleared", 0, MB, 0, 12'd0, 3'd0, 80, 1, 2);

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      logic [47:0] mac; int k;
      k = int'($urandom_range(0, 6));
      case (k)
        0: mac = MA; 1: mac = MB; 2: mac = MC; 3: mac = MD; 4: mac = ME; 5: mac = MF;
        default: mac = {16'h0b00, $urandom()};
      endcase
      step("R6 random", $urandom_range(0, 7) != 0, mac, 1'($urandom_range(0, 1)),
           $urandom_range(0, 1) ? 12'd100 : 12'd101, $urandom_range(0, 1) ? 3'd3 : 3'd4,
           int'($urandom_range(40, 1600)), $urandom_range(0, 7) == 0, int'($urandom_range(0, 7)));
    end

    for (int i = 0; i < NR; i++) step("R9 final", 0, MA, 0, 12'd0, 3'd0, 64, 1, i);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule